// File: doc/BRIEF.md
# Flash Block Protection Controller

This block sits in front of a small nonvolatile memory array, modelled here as a register array, and gates every access to it by block. The array is divided into equal blocks. Each block carries a protection attribute: open, read-only or execute-only. Three request streams arrive: instruction fetches, data reads from the processor or a debugger, and program/erase commands. Allowed requests are carried out. Refused requests report an error, return zeros and change nothing in the array.

Instruction fetches that follow the previous fetch address run back to back. A fetch that jumps to any other address is granted one cycle late. Programming can only clear bits, so only a block erase can set bits back to 1. An accepted command keeps the controller busy for a fixed number of cycles. During that time, reads that target the busy block are held off, and reads to the other blocks are still served. The first protection violation is latched together with its address and stays set until reset.

Top module: `flash_guard`

## Requirements
- R1: After reset every array word reads all ones, every block is open, `viol_o` and `busy_o` are low, and no response is valid.
- R2: A granted data read returns the word one cycle later with `rd_valid_o`. If the block is execute-only, the read instead returns all zeros with `rd_err_o` high.
- R3: A granted fetch returns the word one cycle later with `if_valid_o`, whatever the block's attribute.
- R4: A fetch to the address directly after the previous granted fetch is granted in its first request cycle. Any other fetch, including the first one after reset, is granted one cycle later.
- R5: Program (`cmd_op_i`=0) stores the old word AND `cmd_wdata_i`.
- R6: Erase (`cmd_op_i`=1) sets every word of the block selected by the upper address bits to all ones.
- R7: A program or erase aimed at a read-only or execute-only block is acknowledged with `cmd_err_o`, leaves the array unchanged and does not raise `busy_o`.
- R8: Attribute codes are 0 open, 1 read-only, 2 execute-only. A write is applied only when its code is higher than the block's current code. Lower codes and code 3 are ignored.
- R9: The first denied read or denied command sets `viol_o` and latches its address in `viol_addr_o`. Both hold until reset. A command refused only because the controller is busy is not a violation.
- R10: An accepted command holds `busy_o` high for BUSY_CYC cycles. A command issued while `busy_o` is high is acknowledged with `cmd_err_o` and has no effect.
- R11: While `busy_o` is high, fetches and data reads to the busy block are not granted. Requests to other blocks are granted as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| if_req_i | input | 1 | Fetch request, held until granted |
| if_addr_i | input | AW | Fetch word address |
| if_gnt_o | output | 1 | Fetch granted this cycle |
| if_valid_o | output | 1 | Fetch data valid |
| if_rdata_o | output | DW | Fetch data |
| rd_req_i | input | 1 | Data read request, held until granted |
| rd_addr_i | input | AW | Data read word address |
| rd_gnt_o | output | 1 | Data read granted this cycle |
| rd_valid_o | output | 1 | Data read response valid |
| rd_err_o | output | 1 | Data read refused |
| rd_rdata_o | output | DW | Data read result, zero when refused |
| cmd_req_i | input | 1 | Command strobe, one cycle |
| cmd_op_i | input | 1 | 0 program, 1 erase |
| cmd_addr_i | input | AW | Command word address (block from upper bits) |
| cmd_wdata_i | input | DW | Program data |
| cmd_ack_o | output | 1 | Command response strobe |
| cmd_err_o | output | 1 | Command refused |
| busy_o | output | 1 | Command in progress |
| attr_set_i | input | 1 | Attribute write strobe |
| attr_blk_i | input | BLK_W | Block to update |
| attr_code_i | input | 2 | New attribute code |
| viol_o | output | 1 | Sticky violation flag |
| viol_addr_o | output | AW | Address of first violation |

## Verification
The assertions assume that a fetch or data read request is held with a stable address until it is granted. They also assume that a command strobe lasts one cycle, so that every acknowledgement belongs to exactly one request. The checker's view of a command refused for protection relies on the attribute sampled in the request cycle, so attribute writes are never issued in the same cycle as a command. The bench drives every request through tasks that keep the request raised until the grant and pulse commands for a single cycle. It issues attribute writes only while no other request is pending.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef logic [1:0] attr_t;
  localparam attr_t ATTR_OPEN   = 2'd0;
  localparam attr_t ATTR_RDONLY = 2'd1;
  localparam attr_t ATTR_EXONLY = 2'd2;
  localparam attr_t ATTR_BAD    = 2'd3;
  localparam logic  OP_PROG     = 1'b0;
  localparam logic  OP_ERASE    = 1'b1;
endpackage

// File: rtl/fg_attr_table.sv
module fg_attr_table
  import fg_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int BLK_W   = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    set_i,
  input  logic [BLK_W-1:0]        set_blk_i,
  input  attr_t                   set_code_i,
  output logic [NUM_BLK-1:0][1:0] attr_o
);
  logic [NUM_BLK-1:0] raise;

  // only strictly tighter, valid codes are taken
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_raise
    assign raise[b] = set_i && (set_blk_i == BLK_W'(b)) &&
                      (set_code_i != ATTR_BAD) && (set_code_i > attr_o[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr_o <= '0;
    end else begin
      for (int b = 0; b < NUM_BLK; b++) begin
        if (raise[b]) attr_o[b] <= set_code_i;
      end
    end
  end
endmodule

// File: rtl/fg_fetch_seq.sv
module fg_fetch_seq #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          hold_i,
  output logic          gnt_o
);
  logic [AW-1:0] last_q;
  logic          have_q;
  logic          paid_q;
  logic          seq;

  assign seq   = have_q && (addr_i == last_q + AW'(1));
  assign gnt_o = req_i && !hold_i && (seq || paid_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      have_q <= 1'b0;
      paid_q <= 1'b0;
    end else begin
      // stall cycle is paid once per discontinuity, even while held
      paid_q <= req_i && !gnt_o && !seq;
      if (gnt_o) begin
        last_q <= addr_i;
        have_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fg_busy_ctr.sv
module fg_busy_ctr #(
  parameter int BUSY_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (start_i)   cnt_q <= CW'(BUSY_CYC);
    else if (busy_o)    cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/fg_array.sv
module fg_array #(
  parameter int NUM_BLK   = 4,
  parameter int BLK_WORDS = 64,
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int OFF_W     = 6,
  parameter int BLK_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    ra_addr_i,
  output logic [DW-1:0]    ra_data_o,
  input  logic [AW-1:0]    rb_addr_i,
  output logic [DW-1:0]    rb_data_o,
  input  logic             prog_i,
  input  logic [AW-1:0]    prog_addr_i,
  input  logic [DW-1:0]    prog_data_i,
  input  logic             erase_i,
  input  logic [BLK_W-1:0] erase_blk_i
);
  localparam int WORDS = NUM_BLK * BLK_WORDS;
  logic [DW-1:0] mem [WORDS];

  assign ra_data_o = mem[ra_addr_i];
  assign rb_data_o = mem[rb_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      if (erase_i) begin
        for (int w = 0; w < BLK_WORDS; w++) mem[{erase_blk_i, OFF_W'(w)}] <= '1;
      end
      if (prog_i) mem[prog_addr_i] <= mem[prog_addr_i] & prog_data_i;
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int NUM_BLK   = 4,
  parameter int BLK_WORDS = 64,
  parameter int DW        = 32,
  parameter int BUSY_CYC  = 4,
  parameter int AW        = $clog2(NUM_BLK * BLK_WORDS),
  parameter int BLK_W     = $clog2(NUM_BLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             if_req_i,
  input  logic [AW-1:0]    if_addr_i,
  output logic             if_gnt_o,
  output logic             if_valid_o,
  output logic [DW-1:0]    if_rdata_o,
  input  logic             rd_req_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic             rd_gnt_o,
  output logic             rd_valid_o,
  output logic             rd_err_o,
  output logic [DW-1:0]    rd_rdata_o,
  input  logic             cmd_req_i,
  input  logic             cmd_op_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic [DW-1:0]    cmd_wdata_i,
  output logic             cmd_ack_o,
  output logic             cmd_err_o,
  output logic             busy_o,
  input  logic             attr_set_i,
  input  logic [BLK_W-1:0] attr_blk_i,
  input  logic [1:0]       attr_code_i,
  output logic             viol_o,
  output logic [AW-1:0]    viol_addr_o
);
  localparam int OFF_W = $clog2(BLK_WORDS);

  logic [NUM_BLK-1:0][1:0] attr;
  logic [BLK_W-1:0] if_blk, rd_blk, cmd_blk, busy_blk_q;
  logic if_hold, rd_hold, rd_deny, cmd_take, cmd_deny, cmd_go;
  logic [DW-1:0] if_word, rd_word;

  assign if_blk  = if_addr_i[AW-1 -: BLK_W];
  assign rd_blk  = rd_addr_i[AW-1 -: BLK_W];
  assign cmd_blk = cmd_addr_i[AW-1 -: BLK_W];

  fg_attr_table #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_attr (
    .clk_i, .rst_ni,
    .set_i     (attr_set_i),
    .set_blk_i (attr_blk_i),
    .set_code_i(attr_code_i),
    .attr_o    (attr)
  );

  assign if_hold = busy_o && (if_blk == busy_blk_q);
  assign rd_hold = busy_o && (rd_blk == busy_blk_q);

  fg_fetch_seq #(.AW(AW)) u_seq (
    .clk_i, .rst_ni,
    .req_i (if_req_i),
    .addr_i(if_addr_i),
    .hold_i(if_hold),
    .gnt_o (if_gnt_o)
  );

  assign rd_gnt_o = rd_req_i && !rd_hold;
  assign rd_deny  = (attr[rd_blk] == ATTR_EXONLY);
  assign cmd_take = cmd_req_i && !busy_o;
  assign cmd_deny = (attr[cmd_blk] != ATTR_OPEN);
  assign cmd_go   = cmd_take && !cmd_deny;

  fg_busy_ctr #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk_i, .rst_ni,
    .start_i(cmd_go),
    .busy_o (busy_o)
  );

  fg_array #(
    .NUM_BLK(NUM_BLK), .BLK_WORDS(BLK_WORDS), .DW(DW),
    .AW(AW), .OFF_W(OFF_W), .BLK_W(BLK_W)
  ) u_array (
    .clk_i, .rst_ni,
    .ra_addr_i  (if_addr_i),
    .ra_data_o  (if_word),
    .rb_addr_i  (rd_addr_i),
    .rb_data_o  (rd_word),
    .prog_i     (cmd_go && (cmd_op_i == OP_PROG)),
    .prog_addr_i(cmd_addr_i),
    .prog_data_i(cmd_wdata_i),
    .erase_i    (cmd_go && (cmd_op_i == OP_ERASE)),
    .erase_blk_i(cmd_blk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      if_valid_o  <= 1'b0;
      if_rdata_o  <= '0;
      rd_valid_o  <= 1'b0;
      rd_err_o    <= 1'b0;
      rd_rdata_o  <= '0;
      cmd_ack_o   <= 1'b0;
      cmd_err_o   <= 1'b0;
      busy_blk_q  <= '0;
      viol_o      <= 1'b0;
      viol_addr_o <= '0;
    end else begin
      if_valid_o <= if_gnt_o;
      if (if_gnt_o) if_rdata_o <= if_word;
      rd_valid_o <= rd_gnt_o;
      rd_err_o   <= rd_gnt_o && rd_deny;
      rd_rdata_o <= (rd_gnt_o && !rd_deny) ? rd_word : '0;
      cmd_ack_o  <= cmd_req_i;
      cmd_err_o  <= cmd_req_i && (busy_o || cmd_deny);
      if (cmd_go) busy_blk_q <= cmd_blk;
      // first violation wins; busy refusals are not violations
      if (!viol_o) begin
        if (rd_gnt_o && rd_deny) begin
          viol_o      <= 1'b1;
          viol_addr_o <= rd_addr_i;
        end else if (cmd_take && cmd_deny) begin
          viol_o      <= 1'b1;
          viol_addr_o <= cmd_addr_i;
        end
      end
    end
  end
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int NUM_BLK  = 4,
  parameter int DW       = 32,
  parameter int BUSY_CYC = 4,
  parameter int AW       = 8,
  parameter int BLK_W    = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    if_gnt_o,
  input logic                    if_valid_o,
  input logic                    rd_valid_o,
  input logic                    rd_err_o,
  input logic [DW-1:0]           rd_rdata_o,
  input logic                    cmd_req_i,
  input logic [AW-1:0]           cmd_addr_i,
  input logic                    cmd_ack_o,
  input logic                    cmd_err_o,
  input logic                    busy_o,
  input logic                    viol_o,
  input logic [AW-1:0]           viol_addr_o,
  input logic [NUM_BLK-1:0][1:0] attr
);
  logic [BLK_W-1:0] cblk;
  int run_q;
  assign cblk = cmd_addr_i[AW-1 -: BLK_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  assert_deny_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && rd_err_o |-> rd_rdata_o == '0);

  assert_fetch_resp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_valid_o |-> $past(if_gnt_o));

  assert_protected_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_i && !busy_o && (attr[cblk] != 2'd0) |=> cmd_ack_o && cmd_err_o && !busy_o);

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_mono
    assert_attr_mono_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      attr[b] >= $past(attr[b]));
  end

  assert_viol_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o && $stable(viol_addr_o));

  assert_busy_refuse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_i && busy_o |=> cmd_ack_o && cmd_err_o);

  assert_busy_len_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < BUSY_CYC);
endmodule

bind flash_guard fg_checker #(
  .NUM_BLK(NUM_BLK), .DW(DW), .BUSY_CYC(BUSY_CYC), .AW(AW), .BLK_W(BLK_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .if_gnt_o   (if_gnt_o),
  .if_valid_o (if_valid_o),
  .rd_valid_o (rd_valid_o),
  .rd_err_o   (rd_err_o),
  .rd_rdata_o (rd_rdata_o),
  .cmd_req_i  (cmd_req_i),
  .cmd_addr_i (cmd_addr_i),
  .cmd_ack_o  (cmd_ack_o),
  .cmd_err_o  (cmd_err_o),
  .busy_o     (busy_o),
  .viol_o     (viol_o),
  .viol_addr_o(viol_addr_o),
  .attr       (attr)
);

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int BW = 2;
  localparam int BUSY = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic if_req = 0, rd_req = 0, cmd_req = 0, cmd_op = 0, attr_set = 0;
  logic [AW-1:0] if_addr = '0, rd_addr = '0, cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [BW-1:0] attr_blk = '0;
  logic [1:0] attr_code = '0;
  logic if_gnt, if_valid, rd_gnt, rd_valid, rd_err, cmd_ack, cmd_err, busy, viol;
  logic [DW-1:0] if_rdata, rd_rdata;
  logic [AW-1:0] viol_addr;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  flash_guard #(.NUM_BLK(4), .BLK_WORDS(64), .DW(DW), .BUSY_CYC(BUSY)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .if_req_i(if_req), .if_addr_i(if_addr), .if_gnt_o(if_gnt),
    .if_valid_o(if_valid), .if_rdata_o(if_rdata),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .rd_gnt_o(rd_gnt),
    .rd_valid_o(rd_valid), .rd_err_o(rd_err), .rd_rdata_o(rd_rdata),
    .cmd_req_i(cmd_req), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr),
    .cmd_wdata_i(cmd_wdata), .cmd_ack_o(cmd_ack), .cmd_err_o(cmd_err),
    .busy_o(busy), .attr_set_i(attr_set), .attr_blk_i(attr_blk),
    .attr_code_i(attr_code), .viol_o(viol), .viol_addr_o(viol_addr)
  );

  // {is_fetch, addr, data, err}
  localparam logic [41:0] VEC [7] = '{
    {1'b0, 8'h41, 32'hA5A5A5A5, 1'b0},
    {1'b1, 8'h41, 32'hA5A5A5A5, 1'b0},
    {1'b0, 8'h82, 32'h00000000, 1'b1},
    {1'b1, 8'h82, 32'h0F0F0F0F, 1'b0},
    {1'b0, 8'h05, 32'h12340000, 1'b0},
    {1'b1, 8'hC3, 32'hCAFEF00D, 1'b0},
    {1'b0, 8'hC4, 32'hFFFFFFFF, 1'b0}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic fetch(input logic [AW-1:0] a, output logic [DW-1:0] d, output int st);
    st = 0; if_req = 1; if_addr = a; #1;
    while (!if_gnt) begin @(negedge clk); #1; st++; end
    @(negedge clk);
    if_req = 0;
    chk("R3 fetch valid", 32'(if_valid), 1);
    d = if_rdata;
  endtask

  task automatic dread(input logic [AW-1:0] a, output logic [DW-1:0] d,
                       output logic e, output int wt);
    wt = 0; rd_req = 1; rd_addr = a; #1;
    while (!rd_gnt) begin @(negedge clk); #1; wt++; end
    @(negedge clk);
    rd_req = 0;
    chk("R2 read valid", 32'(rd_valid), 1);
    d = rd_rdata; e = rd_err;
  endtask

  task automatic cmd(input logic op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                     output logic e);
    cmd_req = 1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_req = 0;
    chk("R10 cmd ack", 32'(cmd_ack), 1);
    e = cmd_err;
  endtask

  task automatic set_attr(input logic [BW-1:0] b, input logic [1:0] c);
    attr_set = 1; attr_blk = b; attr_code = c;
    @(negedge clk);
    attr_set = 0;
  endtask

  task automatic idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic e;
    int st;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 viol", 32'(viol), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 if_valid", 32'(if_valid), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 cmd_ack", 32'(cmd_ack), 0);
    dread(8'h05, d, e, st);
    chk("R1 erased word", d, 32'hFFFFFFFF);

    // R5 programming clears bits only; R10 busy length
    cmd(1'b0, 8'h05, 32'h12345678, e);
    chk("R5 prog ok", 32'(e), 0);
    st = 0;
    while (busy) begin st++; @(negedge clk); end
    chk("R10 busy cycles", st, BUSY);
    cmd(1'b0, 8'h05, 32'hFFFF0000, e); idle();
    dread(8'h05, d, e, st);
    chk("R5 AND result", d, 32'h12340000);
    cmd(1'b0, 8'h41, 32'hA5A5A5A5, e); idle();
    cmd(1'b0, 8'h82, 32'h0F0F0F0F, e); idle();
    cmd(1'b0, 8'hC3, 32'hCAFEF00D, e); idle();

    set_attr(2'd1, 2'd1);
    set_attr(2'd2, 2'd2);
    chk("R9 no viol yet", 32'(viol), 0);

    // table: R2 data reads, R3 fetches, R4 branch stall
    for (int i = 0; i < 7; i++) begin
      if (VEC[i][41]) begin
        fetch(VEC[i][40:33], d, st);
        chk("R3 fetch data", d, VEC[i][32:1]);
        chk("R4 branch stall", st, 1);
      end else begin
        dread(VEC[i][40:33], d, e, st);
        chk("R2 read data", d, VEC[i][32:1]);
        chk("R2 read err", 32'(e), 32'(VEC[i][0]));
      end
    end
    chk("R9 viol set", 32'(viol), 1);
    chk("R9 viol addr", 32'(viol_addr), 32'h82);

    // R4 sequential fetch has no stall, next jump does
    fetch(8'hC4, d, st);
    chk("R4 seq stall", st, 0);
    chk("R4 seq data", d, 32'hFFFFFFFF);
    fetch(8'h10, d, st);
    chk("R4 jump stall", st, 1);

    // R7 protected blocks refuse commands
    cmd(1'b0, 8'h41, 32'h0, e);
    chk("R7 prog ro err", 32'(e), 1);
    chk("R7 no busy", 32'(busy), 0);
    dread(8'h41, d, e, st);
    chk("R7 ro unchanged", d, 32'hA5A5A5A5);
    cmd(1'b1, 8'h80, 32'h0, e);
    chk("R7 erase xo err", 32'(e), 1);
    fetch(8'h82, d, st);
    chk("R7 xo unchanged", d, 32'h0F0F0F0F);
    chk("R9 first addr kept", 32'(viol_addr), 32'h82);

    // R6 erase
    cmd(1'b1, 8'h00, 32'h0, e);
    chk("R6 erase ok", 32'(e), 0);
    idle();
    dread(8'h05, d, e, st);
    chk("R6 erased word", d, 32'hFFFFFFFF);

    // R8 attribute ordering
    set_attr(2'd1, 2'd0);
    cmd(1'b0, 8'h41, 32'h0, e);
    chk("R8 lower ignored", 32'(e), 1);
    set_attr(2'd1, 2'd2);
    dread(8'h41, d, e, st);
    chk("R8 raise applied err", 32'(e), 1);
    chk("R8 raise applied data", d, 32'h0);
    set_attr(2'd3, 2'd3);
    cmd(1'b0, 8'hC4, 32'h0, e);
    chk("R8 code3 ignored", 32'(e), 0);
    idle();
    dread(8'hC4, d, e, st);
    chk("R8 block3 programmed", d, 32'h0);

    // R10 refusal while busy, R11 hold only on busy block
    cmd(1'b0, 8'h06, 32'h0000FFFF, e);
    cmd(1'b0, 8'h06, 32'h00000000, e);
    chk("R10 busy refuse", 32'(e), 1);
    dread(8'hC3, d, e, st);
    chk("R11 other block no wait", st, 0);
    chk("R11 other block data", d, 32'hCAFEF00D);
    chk("R11 still busy", 32'(busy), 1);
    dread(8'h06, d, e, st);
    chk("R11 busy block held", 32'(st > 0), 1);
    chk("R10 refused cmd no effect", d, 32'h0000FFFF);
    chk("R9 busy not violation", 32'(viol_addr), 32'h82);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule